// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

This block is a 32-pin general-purpose I/O port reached through a small word-wide register interface. Software picks, for each pin, whether it drives out or reads in. It writes output values and reads back the synchronised level of every pad. Each pin can raise an interrupt on a low level, a high level, a rising edge or a falling edge.

A detected condition sets a sticky pending bit. Software clears a pending bit by writing a 1 to it. A per-pin enable bit decides whether that pending bit drives the interrupt outputs. There is one request line for the lower sixteen pins, one for the upper sixteen, and a third line that is the OR of both.

Pad inputs pass through a two-stage synchroniser. Edges are found by comparing the synchronised level with its value on the previous cycle. Register writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `gpio_sense_port`

## Requirements
- R1: While reset is held, every register reads 0. `pad_oe`, `pad_out` and all three interrupt lines are 0. Reset leaves every pin an input with sense code 00, masked, and not pending.
- R2: The output-value register sits at byte offset 0x00 and the direction register at 0x04. Reads of both return the last value written. `pad_out` follows the output-value register, and `pad_oe` follows the direction register, where 1 means the pin drives.
- R3: A read at offset 0x08 returns `pad_in` as sampled two clock edges earlier, whatever the direction bits are. Writes to 0x08 have no effect.
- R4: Pin k's 2-bit sense code sits in bits [2(k mod 16)+1 : 2(k mod 16)]. Pins 0–15 use the register at offset 0x0C and pins 16–31 use the register at offset 0x10.
- R5: With code 00, the pending bit is set on every cycle the synchronised pin is 0.
- R6: With code 01, the pending bit is set on every cycle the synchronised pin is 1.
- R7: With code 10, the pending bit is set only when the synchronised pin goes from 0 to 1. It stays set after the pin returns to 0.
- R8: With code 11, the pending bit is set only when the synchronised pin goes from 1 to 0. A 0-to-1 change does not set it.
- R9: The pending register is at offset 0x18. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set in the same cycle wins over a clear, so a held level keeps its bit pending.
- R10: The enable register is at offset 0x14, where 1 enables a pin. `irq_lo` is high when any pin 0–15 is both pending and enabled. `irq_hi` does the same for pins 16–31, and `irq_any` is their OR.
- R11: A pending pin whose enable bit is 0 drives no interrupt line. It still reads back as pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value driven toward the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Request for pins 0–15 |
| irq_hi | output | 1 | Request for pins 16–31 |
| irq_any | output | 1 | OR of both request lines |

## Verification
The hardest case to reach is a clear that collides with a level condition that is still present. To get there, the bench holds a pin at its high-level trigger, writes a 1 to that pending bit and checks that the bit reads back still set. It then releases the pad and shows that the same clear now works. The edge modes need a similar kind of care. Each pad change is followed by a wait longer than the synchroniser delay. The bench checks that the opposite edge leaves the pending bit untouched, and that a write of 0 to the pending register changes nothing.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

    localparam int PINS   = 32;
    localparam int HALF   = PINS / 2;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PAD  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CFGL = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFGH = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_PEND = 5'h18;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_FALL = 2'b11
    } sense_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [PINS-1:0]   wdata;
    } bus_req_t;

    function automatic sense_e code_for(input logic [PINS-1:0] cfg_lo,
                                        input logic [PINS-1:0] cfg_hi,
                                        input int pin);
        logic [PINS-1:0] sel;
        int slot;
        sel  = (pin < HALF) ? cfg_lo : cfg_hi;
        slot = pin % HALF;
        return sense_e'(sel[2*slot +: 2]);
    endfunction

endpackage

// File: rtl/gpio_sense_sync.sv
module gpio_sense_sync
    import gpio_sense_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] lvl,
    output logic [PINS-1:0] lvl_prev
);
    logic [PINS-1:0] meta_q;
    logic [1:0]      since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= pad_in;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (lvl == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_sense_detect.sv
module gpio_sense_detect
    import gpio_sense_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] lvl,
    input  logic [PINS-1:0] lvl_prev,
    input  logic [PINS-1:0] cfg_lo,
    input  logic [PINS-1:0] cfg_hi,
    output logic [PINS-1:0] hit
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        sense_e code;
        assign code = code_for(cfg_lo, cfg_hi, i);

        always_comb begin
            unique case (code)
                SENSE_LOW:  hit[i] = ~lvl[i];
                SENSE_HIGH: hit[i] =  lvl[i];
                SENSE_RISE: hit[i] =  lvl[i] & ~lvl_prev[i];
                SENSE_FALL: hit[i] = ~lvl[i] &  lvl_prev[i];
                default:    hit[i] = 1'b0;
            endcase
        end

        // R7
        rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
            (code == SENSE_RISE && hit[i]) |-> (lvl[i] && !$past(lvl[i])));

        // R8
        fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
            (code == SENSE_FALL && hit[i]) |-> (!lvl[i] && $past(lvl[i])));
    end

endmodule

// File: rtl/gpio_sense_regs.sv
module gpio_sense_regs
    import gpio_sense_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  logic [PINS-1:0] lvl,
    input  logic [PINS-1:0] hit,
    output logic [PINS-1:0] rdata,
    output logic [PINS-1:0] data_q,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] cfg_lo,
    output logic [PINS-1:0] cfg_hi,
    output logic            irq_lo,
    output logic            irq_hi,
    output logic            irq_any
);
    logic [PINS-1:0] mask_q;
    logic [PINS-1:0] pend_q;
    logic [PINS-1:0] clr_vec;
    logic [PINS-1:0] active;

    assign clr_vec = (req.wr && req.addr == OFS_PEND) ? req.wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            cfg_lo <= '0;
            cfg_hi <= '0;
            mask_q <= '0;
        end else if (req.wr) begin
            unique case (req.addr)
                OFS_DATA: data_q <= req.wdata;
                OFS_DIR:  dir_q  <= req.wdata;
                OFS_CFGL: cfg_lo <= req.wdata;
                OFS_CFGH: cfg_hi <= req.wdata;
                OFS_MASK: mask_q <= req.wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_vec) | hit;
    end

    always_comb begin
        unique case (req.addr)
            OFS_DATA: rdata = data_q;
            OFS_DIR:  rdata = dir_q;
            OFS_PAD:  rdata = lvl;
            OFS_CFGL: rdata = cfg_lo;
            OFS_CFGH: rdata = cfg_hi;
            OFS_MASK: rdata = mask_q;
            OFS_PEND: rdata = pend_q;
            default:  rdata = '0;
        endcase
    end

    assign active  = pend_q & mask_q;
    assign irq_lo  = |active[HALF-1:0];
    assign irq_hi  = |active[PINS-1:HALF];
    assign irq_any = irq_lo | irq_hi;

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.addr == OFS_DATA) |=> (data_q == $past(req.wdata)));

    // R9
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0));

    // R11
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_any);

endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
    import gpio_sense_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_any
);
    bus_req_t        req;
    logic [PINS-1:0] lvl, lvl_prev, hit, cfg_lo, cfg_hi;

    assign req = '{wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    gpio_sense_sync u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in),
        .lvl(lvl), .lvl_prev(lvl_prev)
    );

    gpio_sense_detect u_detect (
        .clk(clk), .rst(rst), .lvl(lvl), .lvl_prev(lvl_prev),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .hit(hit)
    );

    gpio_sense_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .lvl(lvl), .hit(hit),
        .rdata(bus_rdata), .data_q(pad_out), .dir_q(pad_oe),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    // R10
    irq_split_chk: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> (irq_lo || irq_hi));

endmodule

// File: tb/gpio_sense_port_test.sv
`timescale 1ns/1ps
module gpio_sense_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi, irq_any;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_sense_port uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a <= 24; a += 4) begin
            rd(a[4:0], v);
            check("R1 reg reads zero in reset", v, 32'h0);
        end
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irq lines", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
    endtask

    task automatic t_output();
        logic [31:0] v;
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_0000);
        #1;
        check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
        rd(5'h00, v); check("R2 data readback", v, 32'hA5A5_0F0F);
        rd(5'h04, v); check("R2 dir readback", v, 32'hFFFF_0000);
    endtask

    task automatic t_pad();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(posedge clk);
        #1 bus_addr = 5'h08;
        #1 check("R3 one edge still old", bus_rdata, 32'h0);
        @(posedge clk);
        #1 check("R3 two edges new value", bus_rdata, 32'h1234_5678);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v); check("R3 write ignored", v, 32'h1234_5678);
        set_pad(32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(5'h0C, 32'hAAAA_AAAA);
        wr(5'h10, 32'hAAAA_AAAA);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); check("R7 quiet pads no pending", v, 32'h0);
        set_pad(32'h0000_0008);
        rd(5'h18, v); check("R7 rise on pin 3", v, 32'h0000_0008);
        set_pad(32'h0);
        rd(5'h18, v); check("R7 sticky after fall", v, 32'h0000_0008);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(5'h18, 32'h0);
        rd(5'h18, v); check("R9 zero write no effect", v, 32'h0000_0008);
        wr(5'h18, 32'h0000_0008);
        rd(5'h18, v); check("R9 one write clears", v, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(5'h10, 32'hAAAA_ABAA);
        set_pad(32'h0010_0000);
        rd(5'h18, v); check("R8 rise ignored on falling pin 20", v, 32'h0);
        set_pad(32'h0);
        rd(5'h18, v); check("R8 R4 fall on pin 20", v, 32'h0010_0000);
        wr(5'h18, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(5'h0C, 32'hAAAA_A6AA);
        wr(5'h10, 32'hAAAA_ABA2);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); check("R5 R4 low level pin 17", v, 32'h0002_0000);
        set_pad(32'h0000_0020);
        rd(5'h18, v); check("R6 high level pin 5", v, 32'h0002_0020);
        wr(5'h18, 32'h0000_0020);
        rd(5'h18, v); check("R9 set wins over clear", v, 32'h0002_0020);
        set_pad(32'h0002_0000);
        wr(5'h18, 32'h0002_0020);
        rd(5'h18, v); check("R5 R6 clear after levels end", v, 32'h0);
        repeat (3) @(posedge clk);
        rd(5'h18, v); check("R5 stays clear at high pad", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        set_pad(32'h0012_0008);
        set_pad(32'h0002_0000);
        rd(5'h18, v); check("R7 R8 pend pins 3 and 20", v, 32'h0010_0008);
        wr(5'h14, 32'h0);
        #1 check("R11 masked no irq", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
        wr(5'h14, 32'h0000_0008);
        #1 check("R10 low half irq", {29'h0, irq_lo, irq_hi, irq_any}, 32'h5);
        wr(5'h14, 32'h0010_0000);
        #1 check("R10 high half irq", {29'h0, irq_lo, irq_hi, irq_any}, 32'h3);
        wr(5'h18, 32'hFFFF_FFFF);
        #1 check("R10 cleared no irq", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        t_output();
        t_pad();
        t_rise();
        t_clear();
        t_fall();
        t_level();
        t_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule